// File: doc/BRIEF.md
# Audio Decoder Control Register Bank

This block holds the sixteen-bit control and status words that steer an audio decoder core. A serial control port reaches it through a flat interface: a 4-bit word address, write data, a write strobe and combinational read data. On the other side, the decoder core reports elapsed play time, stream properties and header words through strobed update inputs. The bank drives the configuration the core and the analog output stage need: the mode word, the clock configuration, the volume word, an analog attenuation level, an analog power-down flag, a clock-doubler enable and a one-cycle soft-reset pulse.

The volume word also steers the analog output stage. Each volume write re-derives the attenuation level and power state, so software never has to program them separately. A soft reset clears the decoder-reported state and leaves volume, status and clock setup as they were. The stream-info word is assembled from separate fields in a fixed packed layout.

Top module: `dec_regbank`

## Requirements
- R1: After hardware reset every one of the 15 registers (addresses 0 to 14) reads 0x0000, and the attenuation level, power-down flag, clock-doubler enable and soft-reset pulse are all 0.
- R2: Address map: 0 mode, 1 status, 2 clock configuration, 3 play time, 4 stream info, 5 header word 0, 6 header word 1, 7 volume, 8 to 14 general parameter words. A write to address 0, 1, 2, 7 or 8 to 14 is read back unchanged in the cycle after the write strobe. The exception is the reset bit of the mode word (R5).
- R3: A volume write, with the left attenuation in bits 15:8 and the right in bits 7:0, each counted in 0.5 dB steps, sets status bits 1:0 from the smaller of the two bytes: 0 when it is below 12, 1 when it is below 24, 3 otherwise. It sets status bit 2 (analog power-down) only when both bytes are 255. So 0xFFFF powers down and 0xFEFE does not.
- R4: Bit 15 of the clock configuration word drives the clock-doubler enable. Bits 14:0 are presented unchanged as the clock divide value (input frequency / 2000).
- R5: Writing 1 to mode bit 2 makes the soft-reset output high for exactly the cycle after the write, and that bit reads back 1 in that cycle. In the following cycle the bit reads 0. The play time, stream info and both header words then read 0, while volume, status, clock configuration and the other mode bits keep their values.
- R6: Writes to addresses 3, 4, 5 and 6 are ignored: the values read there are unchanged afterwards.
- R7: A strobe on a decoder-side update input loads the play time, the header words, or the stream fields. Stream info reads with the bit rate in bits 8:0, the sample-rate index in bits 12:9, zeros in bits 14:13 and the stereo flag in bit 15.
- R8: Reading address 15 returns 0x0000.
- R9: A direct write to the status word drives the attenuation level from bits 1:0 and the power-down flag from bit 2 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| wr_en | input | 1 | Write strobe from the control port |
| addr | input | 4 | Word address for read and write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| time_upd | input | 1 | Load play time |
| time_val | input | 16 | Play time in seconds |
| info_upd | input | 1 | Load stream fields |
| info_kbps | input | 9 | Bit rate in kbit/s |
| info_fsidx | input | 4 | Sample-rate index |
| info_stereo | input | 1 | 1 for stereo, 0 for mono |
| hdr_upd | input | 1 | Load both header words |
| hdr0_val | input | 16 | Header word 0 |
| hdr1_val | input | 16 | Header word 1 |
| mode_o | output | 16 | Current mode word |
| vol_o | output | 16 | Current volume word |
| clk_div_o | output | 15 | Clock divide value |
| clk_dbl_en | output | 1 | Clock-doubler enable |
| atten_lvl | output | 2 | Analog output attenuation level |
| analog_pd | output | 1 | Analog section power-down |
| soft_rst_o | output | 1 | One-cycle soft-reset pulse |

## Verification
A corrupted volume-to-status mapping shows on `atten_lvl` and `analog_pd` one cycle after the volume write. Byte pairs near the 12 and 24 step thresholds and the 0xFEFE/0xFFFF pair expose it. A wrong soft-reset sequence shows as a pulse that lasts too long or never appears on `soft_rst_o`, or as decoder-side words that still read nonzero two cycles after the mode write. A changed volume would also be visible then. A packing fault in the stream word, or a read-only word that accepts writes, is visible on `rdata` in the cycle after the stimulus.

// File: rtl/dec_regbank_pkg.sv
package dec_regbank_pkg;
    localparam int DW       = 16;
    localparam int AW       = 4;
    localparam int SPARE_N  = 7;
    localparam int KBPS_W   = 9;
    localparam int FSI_W    = 4;
    localparam int HALF     = DW / 2;

    localparam logic [AW-1:0] A_MODE   = 4'd0;
    localparam logic [AW-1:0] A_STAT   = 4'd1;
    localparam logic [AW-1:0] A_CLK    = 4'd2;
    localparam logic [AW-1:0] A_TIME   = 4'd3;
    localparam logic [AW-1:0] A_INFO   = 4'd4;
    localparam logic [AW-1:0] A_HDR0   = 4'd5;
    localparam logic [AW-1:0] A_HDR1   = 4'd6;
    localparam logic [AW-1:0] A_VOL    = 4'd7;
    localparam logic [AW-1:0] A_SPARE0 = 4'd8;

    localparam int MODE_RST_BIT = 2;
    localparam int LVL_STEP1    = 12;
    localparam int LVL_STEP2    = 24;

    typedef struct packed {
        logic [DW-1:0]               mode;
        logic [DW-1:0]               status;
        logic [DW-1:0]               clkcfg;
        logic [DW-1:0]               ptime;
        logic [KBPS_W-1:0]           kbps;
        logic [FSI_W-1:0]            fsidx;
        logic                        stereo;
        logic [DW-1:0]               hdr0;
        logic [DW-1:0]               hdr1;
        logic [DW-1:0]               vol;
        logic [SPARE_N-1:0][DW-1:0]  spare;
    } bank_t;
endpackage

// File: rtl/dec_vol_map.sv
module dec_vol_map
    import dec_regbank_pkg::*;
(
    input  logic [DW-1:0] vol,
    output logic [1:0]    lvl,
    output logic          pd
);
    logic [HALF-1:0] left_att;
    logic [HALF-1:0] right_att;
    logic [HALF-1:0] min_att;

    always_comb begin
        left_att  = vol[DW-1:HALF];
        right_att = vol[HALF-1:0];
        min_att   = (left_att < right_att) ? left_att : right_att;
        if (min_att < HALF'(LVL_STEP1)) begin
            lvl = 2'd0;
        end else if (min_att < HALF'(LVL_STEP2)) begin
            lvl = 2'd1;
        end else begin
            lvl = 2'd3;
        end
        pd = (left_att == {HALF{1'b1}}) && (right_att == {HALF{1'b1}});
    end
endmodule

// File: rtl/dec_info_pack.sv
module dec_info_pack
    import dec_regbank_pkg::*;
(
    input  logic [KBPS_W-1:0] kbps,
    input  logic [FSI_W-1:0]  fsidx,
    input  logic              stereo,
    output logic [DW-1:0]     word
);
    localparam int PAD_W = DW - 1 - FSI_W - KBPS_W;

    always_comb begin
        word = {stereo, {PAD_W{1'b0}}, fsidx, kbps};
    end
endmodule

// File: rtl/dec_rd_mux.sv
module dec_rd_mux
    import dec_regbank_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  bank_t         bank,
    input  logic [DW-1:0] info_word,
    output logic [DW-1:0] rdata
);
    always_comb begin
        rdata = '0;
        unique case (addr)
            A_MODE: rdata = bank.mode;
            A_STAT: rdata = bank.status;
            A_CLK:  rdata = bank.clkcfg;
            A_TIME: rdata = bank.ptime;
            A_INFO: rdata = info_word;
            A_HDR0: rdata = bank.hdr0;
            A_HDR1: rdata = bank.hdr1;
            A_VOL:  rdata = bank.vol;
            default: begin
                for (int i = 0; i < SPARE_N; i++) begin
                    if (addr == A_SPARE0 + AW'(i)) begin
                        rdata = bank.spare[i];
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/dec_regbank.sv
module dec_regbank
    import dec_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic              time_upd,
    input  logic [DW-1:0]     time_val,
    input  logic              info_upd,
    input  logic [KBPS_W-1:0] info_kbps,
    input  logic [FSI_W-1:0]  info_fsidx,
    input  logic              info_stereo,
    input  logic              hdr_upd,
    input  logic [DW-1:0]     hdr0_val,
    input  logic [DW-1:0]     hdr1_val,
    output logic [DW-1:0]     mode_o,
    output logic [DW-1:0]     vol_o,
    output logic [DW-2:0]     clk_div_o,
    output logic              clk_dbl_en,
    output logic [1:0]        atten_lvl,
    output logic              analog_pd,
    output logic              soft_rst_o
);
    bank_t         bank_d;
    bank_t         bank_q;
    logic [1:0]    new_lvl;
    logic          new_pd;
    logic [DW-1:0] info_word;
    logic          srst_active;

    dec_vol_map u_vol_map (
        .vol (wdata),
        .lvl (new_lvl),
        .pd  (new_pd)
    );

    dec_info_pack u_info_pack (
        .kbps   (bank_q.kbps),
        .fsidx  (bank_q.fsidx),
        .stereo (bank_q.stereo),
        .word   (info_word)
    );

    dec_rd_mux u_rd_mux (
        .addr      (addr),
        .bank      (bank_q),
        .info_word (info_word),
        .rdata     (rdata)
    );

    assign srst_active = bank_q.mode[MODE_RST_BIT];

    always_comb begin
        bank_d = bank_q;

        if (srst_active) begin
            bank_d.mode[MODE_RST_BIT] = 1'b0;
        end

        if (time_upd) begin
            bank_d.ptime = time_val;
        end
        if (info_upd) begin
            bank_d.kbps   = info_kbps;
            bank_d.fsidx  = info_fsidx;
            bank_d.stereo = info_stereo;
        end
        if (hdr_upd) begin
            bank_d.hdr0 = hdr0_val;
            bank_d.hdr1 = hdr1_val;
        end

        if (srst_active) begin
            bank_d.ptime  = '0;
            bank_d.kbps   = '0;
            bank_d.fsidx  = '0;
            bank_d.stereo = 1'b0;
            bank_d.hdr0   = '0;
            bank_d.hdr1   = '0;
        end

        if (wr_en) begin
            unique case (addr)
                A_MODE: bank_d.mode   = wdata;
                A_STAT: bank_d.status = wdata;
                A_CLK:  bank_d.clkcfg = wdata;
                A_VOL: begin
                    bank_d.vol         = wdata;
                    bank_d.status[1:0] = new_lvl;
                    bank_d.status[2]   = new_pd;
                end
                default: begin
                    for (int i = 0; i < SPARE_N; i++) begin
                        if (addr == A_SPARE0 + AW'(i)) begin
                            bank_d.spare[i] = wdata;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign mode_o     = bank_q.mode;
    assign vol_o      = bank_q.vol;
    assign clk_div_o  = bank_q.clkcfg[DW-2:0];
    assign clk_dbl_en = bank_q.clkcfg[DW-1];
    assign atten_lvl  = bank_q.status[1:0];
    assign analog_pd  = bank_q.status[2];
    assign soft_rst_o = srst_active;
endmodule

// File: rtl/dec_regbank_chk.sv
module dec_regbank_chk
    import dec_regbank_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] wdata,
    input logic [DW-1:0] rdata,
    input logic [DW-1:0] vol_o,
    input logic          analog_pd,
    input logic          soft_rst_o,
    input logic          time_upd,
    input logic [DW-1:0] ptime
);
    // R5: the soft-reset pulse never lasts two cycles
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |=> !soft_rst_o);

    // R5: volume survives a soft reset
    a_r5_vol_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst_o && !(wr_en && addr == A_VOL)) |=> $stable(vol_o));

    // R3: power-down follows a volume write of all ones only
    a_r3_pd_from_vol: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_VOL) |=> (analog_pd == ($past(wdata) == 16'hFFFF)));

    // R6: play time ignores control-port writes
    a_r6_time_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_TIME && !time_upd && !soft_rst_o) |=> $stable(ptime));

    // R8: the unused address reads zero
    a_r8_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 4'd15) |-> (rdata == '0));
endmodule

bind dec_regbank dec_regbank_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .vol_o      (vol_o),
    .analog_pd  (analog_pd),
    .soft_rst_o (soft_rst_o),
    .time_upd   (time_upd),
    .ptime      (bank_q.ptime)
);

// File: tb/dec_regbank_tb.sv
module dec_regbank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        time_upd = 1'b0;
    logic [15:0] time_val = '0;
    logic        info_upd = 1'b0;
    logic [8:0]  info_kbps = '0;
    logic [3:0]  info_fsidx = '0;
    logic        info_stereo = 1'b0;
    logic        hdr_upd = 1'b0;
    logic [15:0] hdr0_val = '0;
    logic [15:0] hdr1_val = '0;
    logic [15:0] mode_o;
    logic [15:0] vol_o;
    logic [14:0] clk_div_o;
    logic        clk_dbl_en;
    logic [1:0]  atten_lvl;
    logic        analog_pd;
    logic        soft_rst_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    dec_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .time_upd(time_upd), .time_val(time_val),
        .info_upd(info_upd), .info_kbps(info_kbps), .info_fsidx(info_fsidx),
        .info_stereo(info_stereo), .hdr_upd(hdr_upd), .hdr0_val(hdr0_val),
        .hdr1_val(hdr1_val), .mode_o(mode_o), .vol_o(vol_o),
        .clk_div_o(clk_div_o), .clk_dbl_en(clk_dbl_en), .atten_lvl(atten_lvl),
        .analog_pd(analog_pd), .soft_rst_o(soft_rst_o)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
        end
    endtask

    // one write; returns at the falling edge after the capturing edge
    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [3:0] a, input logic [15:0] exp);
        addr = a;
        #1;
        check(tag, rdata, exp);
    endtask

    task automatic t_reset;
        for (int a = 0; a < 15; a++) rd_check("R1 reg after reset", 4'(a), 16'h0000);
        check("R1 outputs after reset",
              {10'd0, atten_lvl, analog_pd, clk_dbl_en, soft_rst_o, 1'b0}, 16'h0000);
    endtask

    task automatic t_rw;
        wr(4'd0, 16'h1230);
        rd_check("R2 mode readback", 4'd0, 16'h1230);
        check("R2 mode_o", mode_o, 16'h1230);
        for (int a = 8; a < 15; a++) begin
            wr(4'(a), 16'hA500 + 16'(a));
        end
        for (int a = 8; a < 15; a++) rd_check("R2 param readback", 4'(a), 16'hA500 + 16'(a));
    endtask

    task automatic t_vol_one(input logic [15:0] v, input logic [1:0] lvl, input logic pd);
        wr(4'd7, v);
        check("R3 atten_lvl", {14'd0, atten_lvl}, {14'd0, lvl});
        check("R3 analog_pd", {15'd0, analog_pd}, {15'd0, pd});
        rd_check("R3 status bits", 4'd1, {13'd0, pd, lvl});
        rd_check("R2 volume readback", 4'd7, v);
    endtask

    task automatic t_vol;
        t_vol_one(16'h0B30, 2'd0, 1'b0);
        t_vol_one(16'h300C, 2'd1, 1'b0);
        t_vol_one(16'h1817, 2'd1, 1'b0);
        t_vol_one(16'h3018, 2'd3, 1'b0);
        t_vol_one(16'hFEFE, 2'd3, 1'b0);
        t_vol_one(16'hFFFF, 2'd3, 1'b1);
        t_vol_one(16'hFF00, 2'd0, 1'b0);
    endtask

    task automatic t_status;
        wr(4'd1, 16'h0005);
        check("R9 level from status", {14'd0, atten_lvl}, 16'd1);
        check("R9 pd from status", {15'd0, analog_pd}, 16'd1);
        wr(4'd1, 16'h0003);
        check("R9 level 3", {14'd0, atten_lvl}, 16'd3);
        check("R9 pd clear", {15'd0, analog_pd}, 16'd0);
    endtask

    task automatic t_clk;
        wr(4'd2, 16'h8000 | 16'd6144);
        check("R4 doubler on", {15'd0, clk_dbl_en}, 16'd1);
        check("R4 divide", {1'b0, clk_div_o}, 16'd6144);
        wr(4'd2, 16'd12288);
        check("R4 doubler off", {15'd0, clk_dbl_en}, 16'd0);
        check("R4 divide 2", {1'b0, clk_div_o}, 16'd12288);
    endtask

    task automatic t_decoder;
        @(negedge clk);
        time_upd = 1'b1; time_val = 16'd317;
        info_upd = 1'b1; info_kbps = 9'd320; info_fsidx = 4'd11; info_stereo = 1'b1;
        hdr_upd = 1'b1; hdr0_val = 16'hFFFB; hdr1_val = 16'h9064;
        @(negedge clk);
        time_upd = 1'b0; info_upd = 1'b0; hdr_upd = 1'b0;
        rd_check("R7 play time", 4'd3, 16'd317);
        rd_check("R7 info packed", 4'd4, {1'b1, 2'b00, 4'd11, 9'd320});
        rd_check("R7 header 0", 4'd5, 16'hFFFB);
        rd_check("R7 header 1", 4'd6, 16'h9064);
        @(negedge clk);
        info_upd = 1'b1; info_kbps = 9'd128; info_fsidx = 4'd3; info_stereo = 1'b0;
        @(negedge clk);
        info_upd = 1'b0;
        rd_check("R7 info mono", 4'd4, {1'b0, 2'b00, 4'd3, 9'd128});
    endtask

    task automatic t_ro;
        wr(4'd3, 16'h1111);
        rd_check("R6 play time kept", 4'd3, 16'd317);
        wr(4'd4, 16'hFFFF);
        rd_check("R6 info kept", 4'd4, {1'b0, 2'b00, 4'd3, 9'd128});
        wr(4'd5, 16'h2222);
        rd_check("R6 header 0 kept", 4'd5, 16'hFFFB);
        wr(4'd6, 16'h3333);
        rd_check("R6 header 1 kept", 4'd6, 16'h9064);
    endtask

    task automatic t_unused;
        wr(4'd15, 16'hBEEF);
        rd_check("R8 unused read", 4'd15, 16'h0000);
    endtask

    task automatic t_srst;
        wr(4'd7, 16'h2020);
        wr(4'd2, 16'h8ABC);
        wr(4'd0, 16'h0814);
        check("R5 pulse high", {15'd0, soft_rst_o}, 16'd1);
        rd_check("R5 bit reads 1", 4'd0, 16'h0814);
        @(negedge clk);
        check("R5 pulse low", {15'd0, soft_rst_o}, 16'd0);
        rd_check("R5 bit cleared", 4'd0, 16'h0810);
        rd_check("R5 time cleared", 4'd3, 16'h0000);
        rd_check("R5 info cleared", 4'd4, 16'h0000);
        rd_check("R5 header 0 cleared", 4'd5, 16'h0000);
        rd_check("R5 header 1 cleared", 4'd6, 16'h0000);
        rd_check("R5 volume kept", 4'd7, 16'h2020);
        rd_check("R5 clock kept", 4'd2, 16'h8ABC);
        rd_check("R5 status kept", 4'd1, 16'h0003);
        @(negedge clk);
        check("R5 no second pulse", {15'd0, soft_rst_o}, 16'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rw();
        t_vol();
        t_status();
        t_clk();
        t_decoder();
        t_ro();
        t_unused();
        t_srst();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule